// File: doc/BRIEF.md
# Amplifier Fault Supervisor and Restart Sequencer

This block decides whether an amplifier power stage may run. It watches four shutdown causes: an active-low standby request, an active-low undervoltage flag, an active-low overcurrent flag and an 8-bit temperature code. A cause takes effect only after it has been present for its own qualification delay. When any qualified cause is present, the block drops the stage enable and reports standby. Once every cause is gone, it waits for one uninterrupted settling interval before it enables the stage again.

Every delay is counted in ticks of an internal time base, nominally 1 µs, which is derived from the system clock by a divider. A select input swaps all delays and the divider for a second, much shorter parameter set, so that a simulation can exercise the full sequence quickly. The temperature path has hysteresis: it sets at a high threshold and clears only below a lower one.

The controller has three states. In `ST_STANDBY` the stage is off and a cause is present. In `ST_REARM` the stage is off, every cause is clear and the settling timer is running. In `ST_ACTIVE` the stage is enabled. The transitions are:
- `T_CLEAR` (`ST_STANDBY` to `ST_REARM`): at a tick where every raw cause is absent.
- `T_TRIP_R` (`ST_REARM` to `ST_STANDBY`): when any qualified cause is present.
- `T_ARMED` (`ST_REARM` to `ST_ACTIVE`): at a tick where every cause is absent and the settling count is complete.
- `T_TRIP_A` (`ST_ACTIVE` to `ST_STANDBY`): when any qualified cause is present.

If a raw cause appears at a tick during `ST_REARM`, the settling count goes back to zero.

Top module: `amp_fault_sequencer`

## Requirements
- R1: During and after reset the block is in standby, with `stage_en`=0, `status_a`=1 and `status_b`=0. It leaves standby only through a complete settling interval with every cause clear.
- R2: If `standby_n` is held low for at least its standby delay (short set: 5 ticks), the stage is disabled.
- R3: If `uv_n` is held low for at least its undervoltage delay (short set: 6 ticks), the stage is disabled.
- R4: If `oc_n` is held low for at least its overcurrent delay (short set: 2 ticks), the stage is disabled.
- R5: The overtemperature cause sets when the temperature code is 85 or more. A code of 84 never sets it. Once set, it disables the stage after its delay (short set: 8 ticks).
- R6: Once set, the overtemperature cause stays set while the code is 75 to 84. It clears only when the code is below 75.
- R7: A cause that is present for fewer ticks than its delay has no effect on `stage_en`.
- R8: The stage is enabled only after all causes have been clear for the settling interval (short set: 12 ticks). Before that interval ends, `stage_en` stays 0.
- R9: If a raw cause appears at a tick during the settling interval, the interval restarts from zero, even if that cause never qualifies.
- R10: In active mode the status pair is `status_a`=0 and `status_b`=1. In standby it is `status_a`=1 and `status_b`=0. `stage_en` is 1 only in active mode.
- R11: When `short_cnt`=0, the long parameter set applies (one tick per 250 clocks and a settling interval of 1,000,000 ticks). When `short_cnt`=1, the short set applies (one tick per 4 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| short_cnt | input | 1 | 1 selects the shortened delay and tick set |
| standby_n | input | 1 | Standby request, active low |
| uv_n | input | 1 | Undervoltage flag, active low |
| oc_n | input | 1 | Overcurrent flag, active low |
| temp_code | input | 8 | Temperature, unsigned whole degrees Celsius |
| stage_en | output | 1 | Power stage enable |
| status_a | output | 1 | Mode status, high in standby |
| status_b | output | 1 | Mode status, high when active |

## Verification
The bench checks the temperature thresholds at both edges of the hysteresis band. A design that compares with the wrong operator would trip at 84, or release at 75. It applies a fault pulse shorter than the qualification delay, which a design that acts on the first sample would turn into a shutdown. It inserts a sub-threshold glitch halfway through the settling interval and checks that the enable is still low where an unrestarted timer would already have released it. Finally, it holds the long set for many thousand cycles to show that the select input really changes the timebase.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_REARM   = 2'd1,
        ST_ACTIVE  = 2'd2
    } seq_state_t;

    localparam int NSRC   = 4;
    localparam int SRC_SB = 0;
    localparam int SRC_UV = 1;
    localparam int SRC_OC = 2;
    localparam int SRC_OT = 3;

endpackage

// File: rtl/amp_tick_gen.sv
module amp_tick_gen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    // One-cycle pulse every 'div' clocks; the count saturates safely if div shrinks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if ({1'b0, cnt} + 1'b1 >= {1'b0, div}) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/amp_fault_qual.sv
module amp_fault_qual #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          raw,
    input  logic [CW-1:0] lim,
    output logic          qual
);
    logic [CW-1:0] cnt;

    // Counts consecutive ticks with the cause present; any absent sample clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (tick) begin
            if (!raw) begin
                cnt  <= '0;
                qual <= 1'b0;
            end else if ({1'b0, cnt} + 1'b1 >= {1'b0, lim}) begin
                qual <= 1'b1;
            end else begin
                cnt  <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/amp_temp_hyst.sv
module amp_temp_hyst #(
    parameter int TW     = 8,
    parameter int HOT_C  = 85,
    parameter int COOL_C = 75
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [TW-1:0] temp_code,
    output logic          hot
);
    localparam logic [TW-1:0] HOT_T  = TW'(HOT_C);
    localparam logic [TW-1:0] COOL_T = TW'(COOL_C);

    // Temperature is looked at once per tick; inside the band the flag holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot <= 1'b0;
        end else if (tick) begin
            if (temp_code >= HOT_T) begin
                hot <= 1'b1;
            end else if (temp_code < COOL_T) begin
                hot <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/amp_seq_fsm.sv
module amp_seq_fsm
    import amp_seq_pkg::*;
#(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          raw_any,
    input  logic          any_q,
    input  logic [CW-1:0] rearm_lim,
    output logic          stage_en,
    output logic          status_a,
    output logic          status_b
);
    seq_state_t    state, state_nx;
    logic [CW-1:0] wait_cnt;
    logic          wait_done;

    assign wait_done = ({1'b0, wait_cnt} + 1'b1 >= {1'b0, rearm_lim});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STANDBY;
        end else begin
            state <= state_nx;
        end
    end

    // Settling counter: runs only in ST_REARM, restarts on any raw cause seen at a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (state != ST_REARM || (tick && raw_any)) begin
            wait_cnt <= '0;
        end else if (tick && !wait_done) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STANDBY: begin
                if (tick && !raw_any) state_nx = ST_REARM;          // T_CLEAR
            end
            ST_REARM: begin
                if (any_q) state_nx = ST_STANDBY;                   // T_TRIP_R
                else if (tick && !raw_any && wait_done) state_nx = ST_ACTIVE; // T_ARMED
            end
            ST_ACTIVE: begin
                if (any_q) state_nx = ST_STANDBY;                   // T_TRIP_A
            end
            default: state_nx = ST_STANDBY;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ACTIVE: begin
                stage_en = 1'b1;
                status_a = 1'b0;
                status_b = 1'b1;
            end
            ST_STANDBY, ST_REARM: begin
                stage_en = 1'b0;
                status_a = 1'b1;
                status_b = 1'b0;
            end
            default: begin
                stage_en = 1'b0;
                status_a = 1'b1;
                status_b = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/amp_fault_sequencer.sv
module amp_fault_sequencer
    import amp_seq_pkg::*;
#(
    parameter int TICK_DIV       = 250,
    parameter int SHORT_TICK_DIV = 4,
    parameter int DLY_SB         = 10,
    parameter int DLY_UV         = 150,
    parameter int DLY_OC         = 1,
    parameter int DLY_OT         = 1000000,
    parameter int DLY_REARM      = 1000000,
    parameter int SDLY_SB        = 5,
    parameter int SDLY_UV        = 6,
    parameter int SDLY_OC        = 2,
    parameter int SDLY_OT        = 8,
    parameter int SDLY_REARM     = 12,
    parameter int TEMP_W         = 8,
    parameter int HOT_C          = 85,
    parameter int COOL_C         = 75
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_cnt,
    input  logic              standby_n,
    input  logic              uv_n,
    input  logic              oc_n,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              stage_en,
    output logic              status_a,
    output logic              status_b
);
    localparam int MAX_A = (DLY_SB > DLY_UV) ? DLY_SB : DLY_UV;
    localparam int MAX_B = (DLY_OC > DLY_OT) ? DLY_OC : DLY_OT;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_D = (MAX_C > DLY_REARM) ? MAX_C : DLY_REARM;
    localparam int CW    = $clog2(MAX_D + 1);
    localparam int MAXDV = (TICK_DIV > SHORT_TICK_DIV) ? TICK_DIV : SHORT_TICK_DIV;
    localparam int DW    = $clog2(MAXDV + 1);

    logic            tick_w;
    logic            ot_hot_w;
    logic [DW-1:0]   div_sel;
    logic [CW-1:0]   rearm_sel;
    logic [NSRC-1:0] raw_v;
    logic [NSRC-1:0] fault_q_w;
    logic [CW-1:0]   lim_v [NSRC];

    assign div_sel   = short_cnt ? DW'(SHORT_TICK_DIV) : DW'(TICK_DIV);
    assign rearm_sel = short_cnt ? CW'(SDLY_REARM)     : CW'(DLY_REARM);

    assign lim_v[SRC_SB] = short_cnt ? CW'(SDLY_SB) : CW'(DLY_SB);
    assign lim_v[SRC_UV] = short_cnt ? CW'(SDLY_UV) : CW'(DLY_UV);
    assign lim_v[SRC_OC] = short_cnt ? CW'(SDLY_OC) : CW'(DLY_OC);
    assign lim_v[SRC_OT] = short_cnt ? CW'(SDLY_OT) : CW'(DLY_OT);

    assign raw_v[SRC_SB] = ~standby_n;
    assign raw_v[SRC_UV] = ~uv_n;
    assign raw_v[SRC_OC] = ~oc_n;
    assign raw_v[SRC_OT] = ot_hot_w;

    amp_tick_gen #(.DW(DW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_sel),
        .tick  (tick_w)
    );

    amp_temp_hyst #(.TW(TEMP_W), .HOT_C(HOT_C), .COOL_C(COOL_C)) u_temp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .temp_code (temp_code),
        .hot       (ot_hot_w)
    );

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_qual
        amp_fault_qual #(.CW(CW)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_w),
            .raw   (raw_v[gi]),
            .lim   (lim_v[gi]),
            .qual  (fault_q_w[gi])
        );
    end

    amp_seq_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .raw_any   (|raw_v),
        .any_q     (|fault_q_w),
        .rearm_lim (rearm_sel),
        .stage_en  (stage_en),
        .status_a  (status_a),
        .status_b  (status_b)
    );
endmodule

// File: rtl/amp_seq_checker.sv
module amp_seq_checker #(
    parameter int TEMP_W = 8,
    parameter int HOT_C  = 85,
    parameter int COOL_C = 75
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_n,
    input logic              uv_n,
    input logic              oc_n,
    input logic [TEMP_W-1:0] temp_code,
    input logic              stage_en,
    input logic              status_a,
    input logic              status_b,
    input logic              tick,
    input logic              ot_hot,
    input logic [3:0]        fault_q
);
    assert_reset_standby_R1: assert property (@(posedge clk)
        !rst_n |=> (status_a && !status_b && !stage_en));

    assert_status_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_a != status_b) && (stage_en == status_b));

    assert_fault_forces_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_q) |=> !stage_en);

    assert_enable_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_en) |-> $past(standby_n && uv_n && oc_n));

    assert_hot_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && temp_code >= TEMP_W'(HOT_C)) |=> ot_hot);

    assert_band_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && temp_code >= TEMP_W'(COOL_C) && temp_code < TEMP_W'(HOT_C)) |=> $stable(ot_hot));
endmodule

bind amp_fault_sequencer amp_seq_checker #(
    .TEMP_W (TEMP_W),
    .HOT_C  (HOT_C),
    .COOL_C (COOL_C)
) u_amp_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_n (standby_n),
    .uv_n      (uv_n),
    .oc_n      (oc_n),
    .temp_code (temp_code),
    .stage_en  (stage_en),
    .status_a  (status_a),
    .status_b  (status_b),
    .tick      (tick_w),
    .ot_hot    (ot_hot_w),
    .fault_q   (fault_q_w)
);

// File: tb/test_amp_fault_sequencer.sv
module test_amp_fault_sequencer;
    localparam int SDIV = 4;
    localparam int SB   = 5;
    localparam int UV   = 6;
    localparam int OC   = 2;
    localparam int OT   = 8;
    localparam int RA   = 12;

    typedef struct {
        logic  act;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       short_cnt;
    logic       standby_n;
    logic       uv_n;
    logic       oc_n;
    logic [7:0] temp_code;
    logic       stage_en;
    logic       status_a;
    logic       status_b;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    amp_fault_sequencer #(
        .TICK_DIV(250), .SHORT_TICK_DIV(SDIV),
        .SDLY_SB(SB), .SDLY_UV(UV), .SDLY_OC(OC), .SDLY_OT(OT), .SDLY_REARM(RA)
    ) i_amp_fault_sequencer (
        .clk(clk), .rst_n(rst_n), .short_cnt(short_cnt),
        .standby_n(standby_n), .uv_n(uv_n), .oc_n(oc_n), .temp_code(temp_code),
        .stage_en(stage_en), .status_a(status_a), .status_b(status_b)
    );

    task automatic tk(input int n);
        repeat (n * SDIV) @(negedge clk);
    endtask

    task automatic expect_mode(input logic act, input string tag);
        exp_t e;
        e.act = act;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compares queued expectations shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (stage_en !== e.act || status_a !== !e.act || status_b !== e.act) begin
                    n_fail++;
                    $display("FAIL %s: en/a/b=%b%b%b expected %b%b%b",
                             e.tag, stage_en, status_a, status_b, e.act, !e.act, e.act);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; short_cnt = 1'b0; standby_n = 1'b1;
        uv_n = 1'b1; oc_n = 1'b1; temp_code = 8'd25;
        repeat (5) @(negedge clk);
        expect_mode(1'b0, "R1 reset state");
        rst_n = 1'b1;

        // R11: long set keeps the stage off long after the short interval would end
        repeat (20000) @(negedge clk);
        expect_mode(1'b0, "R11 long timebase");
        short_cnt = 1'b1;
        tk(RA + 4);
        expect_mode(1'b1, "R11 short set active R10");

        // R2 with R7 (early sample) and R8 re-arm
        standby_n = 1'b0; tk(2);
        expect_mode(1'b1, "R7 standby before delay");
        tk(SB + 2);
        expect_mode(1'b0, "R2 standby shutdown R10");
        standby_n = 1'b1; tk(RA - 2);
        expect_mode(1'b0, "R8 still waiting");
        tk(5);
        expect_mode(1'b1, "R8 re-armed");

        // R7 glitch, then R3
        uv_n = 1'b0; tk(3); uv_n = 1'b1; tk(1);
        expect_mode(1'b1, "R7 short undervoltage ignored");
        uv_n = 1'b0; tk(UV + 2);
        expect_mode(1'b0, "R3 undervoltage shutdown");
        uv_n = 1'b1; tk(RA + 4);
        expect_mode(1'b1, "R3 recovered");

        // R4, then R9 restart by a sub-threshold glitch
        oc_n = 1'b0; tk(OC + 2);
        expect_mode(1'b0, "R4 overcurrent shutdown");
        oc_n = 1'b1; tk(6);
        oc_n = 1'b0; tk(1); oc_n = 1'b1;
        tk(8);
        expect_mode(1'b0, "R9 timer restarted");
        tk(6);
        expect_mode(1'b1, "R9 re-armed after full interval");

        // R5 threshold edge
        temp_code = 8'd84; tk(OT + 6);
        expect_mode(1'b1, "R5 84 no trip");
        temp_code = 8'd85; tk(OT + 4);
        expect_mode(1'b0, "R5 85 trips");

        // R6 hysteresis edge
        temp_code = 8'd75; tk(RA + 6);
        expect_mode(1'b0, "R6 75 holds");
        temp_code = 8'd74; tk(RA + 5);
        expect_mode(1'b1, "R6 74 releases");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule